// File: doc/BRIEF.md
# Indirect Per-Port Attribute Access Unit

This block lets a host reach a large set of per-port attribute values through two narrow registers. The host first writes a command that names a port, as a bank code, and an attribute number. It then moves the selected value one byte at a time through a single data register, least significant byte first. Ordinary attributes are 32-bit values that come live from counters outside the block and cannot be written. Two attributes per port are 48-bit source-address registers held inside the block; the host can read them and write them.

A read of an ordinary attribute never sees a value that is torn across bytes. The first read after a command copies the whole attribute into a holding register. The remaining bytes come from that copy. The read of the last byte takes a fresh copy, so the next pass starts from a new consistent value. A 48-bit write is collected in a staging buffer. It reaches the target register in one step, on the sixth consecutive write only. A command write, or a read in the middle of the sequence, abandons the collected bytes and leaves the target unchanged.

Host accesses are single-cycle strobes, and every strobe is taken in the cycle it is presented. There is no back-pressure. Read data comes back on a one-cycle valid pulse that cannot be stalled, so the host must capture it when the pulse appears.

Top module: `port_attr_access`

## Requirements
- R1: A command write with bank code 0x10 to 0x1E (ports 0 to 14) and attribute number 0 to 7 raises `sel_ok` from the next cycle. Any other bank code drops `sel_ok` from the next cycle.
- R2: `dat_rvalid` is high for exactly one cycle, the cycle after an accepted `dat_rd`, and carries the byte in `dat_rdata`.
- R3: The first read after a command returns byte 0 of the attribute's current value and copies the full value into the holding register. Each later read returns the next byte up from that copy.
- R4: The read of the last byte (byte 3 for 32-bit attributes, byte 5 for 48-bit ones) copies the current value into the holding register again. The next read returns byte 0 of that new copy.
- R5: Attributes 6 (last source address) and 7 (preferred source address) are 48-bit and come from internal storage. Every other attribute a of port p is 32-bit and is taken from `attr_in[(p*8+a)*32 +: 32]`.
- R6: Six consecutive accepted writes to a 48-bit attribute replace it in one step on the sixth write. Write k supplies byte k. The new value appears at `[p*48 +: 48]` of `last_src_out` or `pref_src_out` in the next cycle. No other access changes either output.
- R7: A command write abandons any read or write sequence in progress. A partially written value is dropped, and the next read starts at byte 0 with a fresh copy.
- R8: A read that arrives during a partial 48-bit write drops the collected bytes and is served as a first read (byte 0, fresh copy).
- R9: A write to a 32-bit attribute changes no stored value, but it moves the byte position up by one, wrapping from 3 to 0.
- R10: While `sel_ok` is low, a read returns 0x00 on a valid pulse and a write has no effect.
- R11: In one cycle, a command write takes precedence over a read, and a read takes precedence over a write. The access that loses is discarded and produces no valid pulse.
- R12: After a 48-bit commit, the next read takes a fresh copy that includes the new value.
- R13: After reset, `sel_ok` and `dat_rvalid` are low and both source-address outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_bank | input | 8 | Bank code selecting the port |
| cmd_attr | input | 3 | Attribute number |
| dat_rd | input | 1 | Data register read strobe |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Write byte |
| attr_in | input | 3840 | Live 32-bit attributes, flat per port and attribute |
| dat_rvalid | output | 1 | Read byte valid, one-cycle pulse |
| dat_rdata | output | 8 | Read byte |
| sel_ok | output | 1 | Current selection is valid |
| last_src_out | output | 720 | Stored last source address per port, 48 bits each |
| pref_src_out | output | 720 | Stored preferred source address per port, 48 bits each |

## Verification
Accesses can collide in the same cycle, and the bench provokes each collision on purpose. A command write is driven together with a read. A command write is driven together with the sixth byte of a 48-bit write, and that write must not commit. A read is driven together with a write during a partial sequence. The reference model applies the precedence rule independently. On every clock it compares the valid pulse, the read byte, the selection flag and every stored address, so a design that lets the losing access act is caught.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int NARROW_W = 32;
  localparam int WIDE_W   = 48;

  typedef enum logic [1:0] {
    KIND_RO   = 2'd0,
    KIND_LAST = 2'd1,
    KIND_PREF = 2'd2
  } kind_t;

  function automatic logic [7:0] pick_byte(input logic [WIDE_W-1:0] v, input logic [2:0] i);
    pick_byte = v[{i, 3'b000} +: 8];
  endfunction
endpackage

// File: rtl/pa_sel_decode.sv
module pa_sel_decode
  import pa_pkg::*;
#(
  parameter int NPORTS    = 15,
  parameter int NATTR     = 8,
  parameter int BANK_BASE = 16,
  parameter int LAST_IDX  = 6,
  parameter int PREF_IDX  = 7,
  parameter int PW        = 4,
  parameter int AW        = 3
) (
  input  logic [7:0]    bank,
  input  logic [AW-1:0] attr,
  output logic          ok,
  output logic [PW-1:0] port,
  output kind_t         kind
);
  logic [7:0] off;
  logic       bank_hit;
  logic       attr_hit;

  always_comb begin
    off      = bank - 8'(BANK_BASE);
    bank_hit = (int'(bank) >= BANK_BASE) && (int'(bank) < BANK_BASE + NPORTS);
    attr_hit = int'(attr) < NATTR;
    ok       = bank_hit && attr_hit;
    port     = ok ? off[PW-1:0] : '0;
    if (ok && int'(attr) == LAST_IDX)      kind = KIND_LAST;
    else if (ok && int'(attr) == PREF_IDX) kind = KIND_PREF;
    else                                   kind = KIND_RO;
  end
endmodule

// File: rtl/pa_addr_store.sv
module pa_addr_store
  import pa_pkg::*;
#(
  parameter int NPORTS = 15,
  parameter int PW     = 4,
  parameter int VW     = WIDE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [PW-1:0]      commit_port,
  input  logic               commit_pref,
  input  logic [VW-1:0]      commit_val,
  input  logic [PW-1:0]      rd_port,
  output logic [NPORTS*VW-1:0] last_flat,
  output logic [NPORTS*VW-1:0] pref_flat,
  output logic [VW-1:0]      rd_last,
  output logic [VW-1:0]      rd_pref
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [VW-1:0] last_r;
    logic [VW-1:0] pref_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        last_r <= '0;
        pref_r <= '0;
      end else if (commit && int'(commit_port) == p) begin
        if (commit_pref) pref_r <= commit_val;
        else             last_r <= commit_val;
      end
    end
    assign last_flat[p*VW +: VW] = last_r;
    assign pref_flat[p*VW +: VW] = pref_r;
  end

  always_comb begin
    rd_last = '0;
    rd_pref = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (int'(rd_port) == p) begin
        rd_last = last_flat[p*VW +: VW];
        rd_pref = pref_flat[p*VW +: VW];
      end
    end
  end
endmodule

// File: rtl/pa_byte_seq.sv
module pa_byte_seq
  import pa_pkg::*;
#(
  parameter int VW = WIDE_W,
  parameter int NW = NARROW_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          dat_rd,
  input  logic          dat_wr,
  input  logic [7:0]    wdata,
  input  logic          sel_ok,
  input  logic          wide,
  input  logic [VW-1:0] live,
  output logic          rvalid,
  output logic [7:0]    rdata,
  output logic          commit,
  output logic [VW-1:0] commit_val
);
  localparam int NB_WIDE   = VW / 8;
  localparam int NB_NARROW = NW / 8;

  logic [2:0]    idx;
  logic          primed;
  logic          pend;
  logic [VW-1:0] hold;
  logic [7:0]    wbuf [NB_WIDE];

  logic [2:0] last_b;
  logic [2:0] r_idx;
  logic       r_primed;
  logic [2:0] w_idx;
  logic       rd_go;
  logic       wr_go;
  logic [7:0] r_byte;

  always_comb begin
    last_b   = wide ? 3'(NB_WIDE - 1) : 3'(NB_NARROW - 1);
    rd_go    = dat_rd && !cmd_wr;
    wr_go    = dat_wr && !dat_rd && !cmd_wr && sel_ok;
    r_idx    = pend ? 3'd0 : idx;
    r_primed = pend ? 1'b0 : primed;
    w_idx    = pend ? idx : 3'd0;
    r_byte   = r_primed ? pick_byte(hold, r_idx) : pick_byte(live, r_idx);
    commit   = wr_go && wide && (w_idx == 3'(NB_WIDE - 1));
    commit_val = {wdata, wbuf[4], wbuf[3], wbuf[2], wbuf[1], wbuf[0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx    <= '0;
      primed <= 1'b0;
      pend   <= 1'b0;
      hold   <= '0;
      rvalid <= 1'b0;
      rdata  <= '0;
      for (int k = 0; k < NB_WIDE; k++) wbuf[k] <= '0;
    end else begin
      rvalid <= 1'b0;
      if (cmd_wr) begin
        idx    <= '0;
        primed <= 1'b0;
        pend   <= 1'b0;
      end else if (rd_go) begin
        rvalid <= 1'b1;
        if (!sel_ok) begin
          rdata <= 8'h00;
        end else begin
          rdata  <= r_byte;
          pend   <= 1'b0;
          primed <= 1'b1;
          if (!r_primed) hold <= live;
          if (r_idx == last_b) begin
            idx  <= '0;
            hold <= live;
          end else begin
            idx <= r_idx + 3'd1;
          end
        end
      end else if (wr_go) begin
        if (wide) begin
          if (commit) begin
            idx    <= '0;
            pend   <= 1'b0;
            primed <= 1'b0;
          end else begin
            wbuf[w_idx] <= wdata;
            idx         <= w_idx + 3'd1;
            pend        <= 1'b1;
          end
        end else begin
          idx <= (idx == last_b) ? 3'd0 : idx + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/port_attr_access.sv
module port_attr_access
  import pa_pkg::*;
#(
  parameter int NPORTS    = 15,
  parameter int NATTR     = 8,
  parameter int BANK_BASE = 16,
  parameter int LAST_IDX  = 6,
  parameter int PREF_IDX  = 7,
  parameter int AVW       = NARROW_W,
  parameter int SVW       = WIDE_W,
  localparam int PW       = $clog2(NPORTS),
  localparam int AW       = $clog2(NATTR)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_wr,
  input  logic [7:0]              cmd_bank,
  input  logic [AW-1:0]           cmd_attr,
  input  logic                    dat_rd,
  input  logic                    dat_wr,
  input  logic [7:0]              dat_wdata,
  input  logic [NPORTS*NATTR*AVW-1:0] attr_in,
  output logic                    dat_rvalid,
  output logic [7:0]              dat_rdata,
  output logic                    sel_ok,
  output logic [NPORTS*SVW-1:0]   last_src_out,
  output logic [NPORTS*SVW-1:0]   pref_src_out
);
  logic          dec_ok;
  logic [PW-1:0] dec_port;
  kind_t         dec_kind;

  logic [PW-1:0] port_q;
  logic [AW-1:0] attr_q;
  kind_t         kind_q;

  logic [SVW-1:0] rd_last;
  logic [SVW-1:0] rd_pref;
  logic [SVW-1:0] live_val;
  logic           commit;
  logic [SVW-1:0] commit_val;
  logic           is_wide;

  pa_sel_decode #(
    .NPORTS(NPORTS), .NATTR(NATTR), .BANK_BASE(BANK_BASE),
    .LAST_IDX(LAST_IDX), .PREF_IDX(PREF_IDX), .PW(PW), .AW(AW)
  ) u_dec (
    .bank(cmd_bank), .attr(cmd_attr),
    .ok(dec_ok), .port(dec_port), .kind(dec_kind)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_ok <= 1'b0;
      port_q <= '0;
      attr_q <= '0;
      kind_q <= KIND_RO;
    end else if (cmd_wr) begin
      sel_ok <= dec_ok;
      port_q <= dec_port;
      attr_q <= dec_ok ? cmd_attr : '0;
      kind_q <= dec_kind;
    end
  end

  assign is_wide = (kind_q != KIND_RO);

  always_comb begin
    case (kind_q)
      KIND_LAST: live_val = rd_last;
      KIND_PREF: live_val = rd_pref;
      default:   live_val = {{(SVW-AVW){1'b0}},
                             attr_in[(int'(port_q)*NATTR + int'(attr_q))*AVW +: AVW]};
    endcase
  end

  pa_addr_store #(.NPORTS(NPORTS), .PW(PW), .VW(SVW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .commit(commit), .commit_port(port_q), .commit_pref(kind_q == KIND_PREF),
    .commit_val(commit_val), .rd_port(port_q),
    .last_flat(last_src_out), .pref_flat(pref_src_out),
    .rd_last(rd_last), .rd_pref(rd_pref)
  );

  pa_byte_seq #(.VW(SVW), .NW(AVW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .dat_rd(dat_rd), .dat_wr(dat_wr), .wdata(dat_wdata),
    .sel_ok(sel_ok), .wide(is_wide), .live(live_val),
    .rvalid(dat_rvalid), .rdata(dat_rdata),
    .commit(commit), .commit_val(commit_val)
  );
endmodule

// File: rtl/port_attr_access_chk.sv
module port_attr_access_chk #(
  parameter int NPORTS    = 15,
  parameter int SVW       = 48,
  parameter int BANK_BASE = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_wr,
  input logic [7:0]            cmd_bank,
  input logic                  dat_rd,
  input logic                  dat_wr,
  input logic                  dat_rvalid,
  input logic [7:0]            dat_rdata,
  input logic                  sel_ok,
  input logic [NPORTS*SVW-1:0] last_src_out,
  input logic [NPORTS*SVW-1:0] pref_src_out
);
  assert_rd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !cmd_wr) |=> dat_rvalid);

  assert_no_stray_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr || !dat_rd) |=> !dat_rvalid);

  assert_invalid_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !cmd_wr && !sel_ok) |=> (dat_rdata == 8'h00));

  assert_store_only_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dat_wr || dat_rd || cmd_wr || !sel_ok) |=> ($stable(last_src_out) && $stable(pref_src_out)));

  assert_low_bank_invalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (int'(cmd_bank) < BANK_BASE)) |=> !sel_ok);
endmodule

bind port_attr_access port_attr_access_chk #(
  .NPORTS(NPORTS), .SVW(SVW), .BANK_BASE(BANK_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_bank(cmd_bank),
  .dat_rd(dat_rd), .dat_wr(dat_wr), .dat_rvalid(dat_rvalid), .dat_rdata(dat_rdata),
  .sel_ok(sel_ok), .last_src_out(last_src_out), .pref_src_out(pref_src_out)
);

// File: tb/sim_port_attr_access.sv
module sim_port_attr_access;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 15;
  localparam int NA = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [7:0] cmd_bank = '0;
  logic [2:0] cmd_attr = '0;
  logic dat_rd = 1'b0;
  logic dat_wr = 1'b0;
  logic [7:0] dat_wdata = '0;
  logic [NP*NA*32-1:0] attr_in;
  logic dat_rvalid;
  logic [7:0] dat_rdata;
  logic sel_ok;
  logic [NP*48-1:0] last_src_out;
  logic [NP*48-1:0] pref_src_out;

  int checks = 0;
  int fails = 0;
  int tick = 0;
  bit done = 0;
  string cur_req = "R13";

  always #(CLK_PERIOD/2) clk = ~clk;

  port_attr_access u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_bank(cmd_bank), .cmd_attr(cmd_attr),
    .dat_rd(dat_rd), .dat_wr(dat_wr), .dat_wdata(dat_wdata), .attr_in(attr_in),
    .dat_rvalid(dat_rvalid), .dat_rdata(dat_rdata), .sel_ok(sel_ok),
    .last_src_out(last_src_out), .pref_src_out(pref_src_out)
  );

  function automatic logic [31:0] live32(input int p, input int a, input int t);
    return {8'(p + 1), 8'(a * 17), 16'(t * 3 + 1)};
  endfunction

  always_comb
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < NA; a++)
        attr_in[(p*NA + a)*32 +: 32] = live32(p, a, tick);

  // ---------------- behavioural reference model ----------------
  bit m_ok;
  int m_port, m_attr, m_idx;
  bit m_primed, m_pend;
  byte unsigned snap [6];
  byte unsigned wq [$];
  logic [47:0] m_last [NP];
  logic [47:0] m_pref [NP];
  bit exp_rv;
  byte unsigned exp_rd;

  function automatic int cur_len();
    return (m_attr == 6 || m_attr == 7) ? 6 : 4;
  endfunction

  function automatic byte unsigned live_byte(input int k);
    logic [47:0] v;
    if (m_attr == 6)      v = m_last[m_port];
    else if (m_attr == 7) v = m_pref[m_port];
    else                  v = {16'h0, live32(m_port, m_attr, tick)};
    return v[k*8 +: 8];
  endfunction

  task automatic take_snap();
    for (int k = 0; k < 6; k++) snap[k] = live_byte(k);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ok = 0; m_port = 0; m_attr = 0; m_idx = 0; m_primed = 0; m_pend = 0;
      exp_rv = 0; exp_rd = 0; wq.delete();
      for (int p = 0; p < NP; p++) begin m_last[p] = '0; m_pref[p] = '0; end
    end else begin
      exp_rv = 0;
      if (cmd_wr) begin
        m_ok = (cmd_bank >= 8'h10) && (cmd_bank <= 8'h1E);
        m_port = m_ok ? int'(cmd_bank) - 16 : 0;
        m_attr = m_ok ? int'(cmd_attr) : 0;
        m_idx = 0; m_primed = 0; m_pend = 0; wq.delete();
      end else if (dat_rd) begin
        exp_rv = 1;
        if (!m_ok) exp_rd = 0;
        else begin
          if (m_pend) begin m_pend = 0; m_idx = 0; m_primed = 0; wq.delete(); end
          if (!m_primed) begin take_snap(); m_primed = 1; end
          exp_rd = snap[m_idx];
          if (m_idx == cur_len() - 1) begin m_idx = 0; take_snap(); end
          else m_idx++;
        end
      end else if (dat_wr && m_ok) begin
        if (cur_len() == 6) begin
          if (!m_pend) begin wq.delete(); m_idx = 0; end
          wq.push_back(dat_wdata);
          m_pend = 1; m_idx++;
          if (wq.size() == 6) begin
            for (int k = 0; k < 6; k++) begin
              if (m_attr == 6) m_last[m_port][k*8 +: 8] = wq[k];
              else             m_pref[m_port][k*8 +: 8] = wq[k];
            end
            wq.delete(); m_pend = 0; m_idx = 0; m_primed = 0;
          end
        end else begin
          m_idx = (m_idx + 1) % 4;
        end
      end
    end
  end

  // ---------------- per-clock comparison ----------------
  always @(negedge clk) begin
    if (!done) begin
      tick <= tick + 1;
      checks++;
      if (dat_rvalid !== exp_rv) begin
        fails++;
        $display("FAIL %s rvalid act=%0b exp=%0b t=%0t", cur_req, dat_rvalid, exp_rv, $time);
      end
      if (exp_rv) begin
        checks++;
        if (dat_rdata !== exp_rd) begin
          fails++;
          $display("FAIL %s rdata act=%02h exp=%02h t=%0t", cur_req, dat_rdata, exp_rd, $time);
        end
      end
      checks++;
      if (sel_ok !== m_ok) begin
        fails++;
        $display("FAIL %s sel_ok act=%0b exp=%0b t=%0t", cur_req, sel_ok, m_ok, $time);
      end
      for (int p = 0; p < NP; p++) begin
        checks++;
        if (last_src_out[p*48 +: 48] !== m_last[p] || pref_src_out[p*48 +: 48] !== m_pref[p]) begin
          fails++;
          $display("FAIL %s store port %0d act=%012h/%012h exp=%012h/%012h", cur_req, p,
                   last_src_out[p*48 +: 48], pref_src_out[p*48 +: 48], m_last[p], m_pref[p]);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input bit c, input logic [7:0] b, input logic [2:0] a,
                      input bit r, input bit w, input logic [7:0] d);
    @(negedge clk);
    cmd_wr = c; cmd_bank = b; cmd_attr = a; dat_rd = r; dat_wr = w; dat_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic sel(input logic [7:0] b, input logic [2:0] a);
    step(1, b, a, 0, 0, 0);
  endtask

  task automatic rd(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1, 0, 0);
  endtask

  task automatic wr(input logic [7:0] d);
    step(0, 0, 0, 0, 1, d);
  endtask

  task automatic direct_check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%012h exp=%012h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cur_req = "R13";
    idle(3);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R1"; sel(8'h10, 3'd0); idle(1);
    cur_req = "R3"; rd(2); idle(3); rd(2);
    cur_req = "R4"; rd(4); idle(2); rd(3);
    cur_req = "R5"; sel(8'h1E, 3'd5); rd(4);
    cur_req = "R2"; rd(1); idle(1); rd(1);

    cur_req = "R10"; sel(8'h1F, 3'd0); rd(2); wr(8'h55);
    sel(8'h0F, 3'd6); rd(1); wr(8'h11);

    cur_req = "R6"; sel(8'h12, 3'd6);
    for (int k = 0; k < 6; k++) wr(8'hA0 + 8'(k));
    idle(1);
    direct_check("R6", last_src_out[2*48 +: 48], 48'hA5A4_A3A2_A1A0);
    cur_req = "R12"; rd(6); rd(2);

    cur_req = "R6"; sel(8'h1E, 3'd7);
    for (int k = 0; k < 6; k++) wr(8'h30 + 8'(k));
    idle(1);
    direct_check("R6", pref_src_out[14*48 +: 48], 48'h3534_3332_3130);

    cur_req = "R7"; sel(8'h12, 3'd6);
    wr(8'h01); wr(8'h02); wr(8'h03);
    sel(8'h12, 3'd6); rd(6); idle(1);
    direct_check("R7", last_src_out[2*48 +: 48], 48'hA5A4_A3A2_A1A0);

    cur_req = "R8"; wr(8'h11); wr(8'h22); rd(1); wr(8'h33); rd(3);
    idle(1);

    cur_req = "R9"; sel(8'h13, 3'd2); wr(8'hFF); wr(8'hFF); rd(4); wr(8'h00); rd(3);

    cur_req = "R11"; sel(8'h14, 3'd1);
    step(1, 8'h14, 3'd3, 1, 0, 0);
    rd(2);
    sel(8'h15, 3'd6);
    for (int k = 0; k < 5; k++) wr(8'hC0 + 8'(k));
    step(1, 8'h15, 3'd6, 0, 1, 8'hC5);
    idle(1);
    direct_check("R11", last_src_out[5*48 +: 48], 48'h0);
    wr(8'h01); step(0, 0, 0, 1, 1, 8'h02); rd(2);
    step(1, 8'h10, 3'd1, 1, 1, 8'h09);
    idle(3);

    finish_run();
  end
endmodule